// File: doc/BRIEF.md
# Paged Memory Mapper

This block translates the 16-bit logical address of a Z80-class CPU into a physical memory address. The 64K logical space is split into eight 8K windows. Each window holds an 8-bit page number taken from a small slot table, so any 8K RAM page can appear in any window. When the first two windows hold the code 0xFF, they show ROM instead of RAM. The ROM can come from one of four 16K main ROM images or from a 32K alternate ROM.

Older software pages memory in 16K banks through three I/O ports. A write to the main banking port or to the extension port picks a 16K bank and rewrites the last two windows with that bank's two 8K halves. A lock bit freezes all three legacy ports until reset. Any page number at or above the installed RAM size is flagged as unmapped, and CPU reads from it return 0xFF.

All outputs are registered. A CPU address applied before a rising edge produces its translation right after that edge. A slot-table or port write applied before an edge affects translations sampled at later edges.

Top module: `mem_page_mapper`

## Requirements
- R1: After reset, windows 0 and 1 hold 0xFF (ROM 0). Windows 2 to 7 hold pages 10, 11, 4, 5, 0 and 1, and every legacy register is zero.
- R2: For a RAM window, `phys_addr` is {page, cpu_addr[12:0]}, registered one cycle after `cpu_addr` is sampled. `rom_sel` is 0 in that case.
- R3: When window 0 or 1 holds 0xFF, `rom_sel` is 1 and `phys_addr` is {rom_num, cpu_addr[13:0]}. Here rom_num is {bit 2 of the last 0x1FFD write, bit 4 of the last 0x7FFD write}.
- R4: In windows 2 to 7, the value 0xFF is an ordinary RAM page number (page 255).
- R5: An accepted write to port 0x7FFD stores bank bits [2:0] from data bits [2:0], the ROM low bit from data bit 4 and the lock from data bit 5. It then sets window 6 to page 2N and window 7 to page 2N+1, where N = {ext[3:0], data[2:0]}.
- R6: An accepted write to port 0xDFFD stores data bits [3:0] as the high bank bits ext[3:0] and rewrites windows 6 and 7 in the same way as R5.
- R7: Once the lock bit is set, writes to 0x7FFD, 0x1FFD and 0xDFFD have no effect until reset. Slot-table writes still take effect.
- R8: A RAM page number that is greater than or equal to `RAM_PAGES` raises `unmapped`. While `unmapped` is set, `cpu_rdata` is 0xFF; otherwise `cpu_rdata` equals `mem_rdata`.
- R9: With `altrom_en` set, a ROM access sets `alt_sel` and `phys_addr` becomes {ROM low bit, cpu_addr[13:0]} within the 32K alternate ROM.
- R10: When a slot-table write and a legacy rewrite hit window 6 or 7 in the same cycle, the slot-table write wins for the window it names.
- R11: Port decoding compares all 16 bits, so writes to any other port number change nothing.
- R12: Reset restores the R1 state and clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU logical address |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 16 | I/O port number |
| io_data | input | 8 | I/O write data |
| slot_wr | input | 1 | Slot-table write strobe |
| slot_idx | input | 3 | Window index to write |
| slot_data | input | 8 | Page number to store |
| altrom_en | input | 1 | Redirect ROM accesses to the alternate ROM |
| mem_rdata | input | 8 | Read data returned by memory |
| phys_addr | output | 21 | Registered physical address |
| rom_sel | output | 1 | Access targets ROM |
| alt_sel | output | 1 | Access targets the alternate ROM |
| unmapped | output | 1 | RAM page lies beyond installed RAM |
| cpu_rdata | output | 8 | Read data to CPU, forced to 0xFF when unmapped |

## Verification
The bench builds the mapper with `RAM_PAGES` set to 96, which is the 768K base configuration, instead of the 224-page default. This puts the unmapped boundary between pages 95 and 96, so the bench can test it with direct slot writes. It can also reach it through legacy banks at or above 48, which need extension-port bits.

With that setting, a single extension-port write can push windows 6 and 7 past installed RAM. The same-cycle conflict between a slot write and a port rewrite is also easy to observe, because the overwritten window lands above the limit.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  localparam logic [15:0] PORT_BANK = 16'h7FFD;
  localparam logic [15:0] PORT_ROMX = 16'h1FFD;
  localparam logic [15:0] PORT_BHI  = 16'hDFFD;
  localparam logic [7:0]  ROM_CODE  = 8'hFF;

  typedef struct packed {
    logic [3:0] bank_hi;
    logic       rom_hi;
    logic       lock;
    logic       rom_lo;
    logic [2:0] bank_lo;
  } legacy_t;

  function automatic logic [7:0] boot_page(input int slot);
    case (slot)
      0, 1:    boot_page = ROM_CODE;
      2:       boot_page = 8'd10;
      3:       boot_page = 8'd11;
      4:       boot_page = 8'd4;
      5:       boot_page = 8'd5;
      6:       boot_page = 8'd0;
      default: boot_page = 8'd1;
    endcase
  endfunction
endpackage

// File: rtl/pmm_legacy_ports.sv
module pmm_legacy_ports
  import pmm_pkg::*;
#(
  parameter int BANK_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [15:0]       io_port,
  input  logic [7:0]        io_data,
  output legacy_t           st,
  output logic              remap_stb,
  output logic [BANK_W-1:0] remap_bank
);
  logic hit_bank, hit_romx, hit_bhi;
  logic [2:0] lo_n;
  logic [3:0] hi_n;

  always_comb begin
    hit_bank   = io_wr && !st.lock && (io_port == PORT_BANK);
    hit_romx   = io_wr && !st.lock && (io_port == PORT_ROMX);
    hit_bhi    = io_wr && !st.lock && (io_port == PORT_BHI);
    lo_n       = hit_bank ? io_data[2:0] : st.bank_lo;
    hi_n       = hit_bhi  ? io_data[3:0] : st.bank_hi;
    remap_stb  = hit_bank || hit_bhi;
    remap_bank = BANK_W'({hi_n, lo_n});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      if (hit_bank) begin
        st.bank_lo <= io_data[2:0];
        st.rom_lo  <= io_data[4];
        st.lock    <= io_data[5];
      end
      if (hit_romx) st.rom_hi  <= io_data[2];
      if (hit_bhi)  st.bank_hi <= io_data[3:0];
    end
  end
endmodule

// File: rtl/pmm_slot_table.sv
module pmm_slot_table
  import pmm_pkg::*;
#(
  parameter int SLOT_N = 8,
  parameter int PAGE_W = 8,
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int BANK_W = PAGE_W - 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          slot_wr,
  input  logic [SLOT_W-1:0]             slot_idx,
  input  logic [PAGE_W-1:0]             slot_data,
  input  logic                          remap_stb,
  input  logic [BANK_W-1:0]             remap_bank,
  output logic [SLOT_N-1:0][PAGE_W-1:0] tbl
);
  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    localparam bit IS_TOP = (s >= SLOT_N - 2);
    localparam logic HALF = 1'(s - (SLOT_N - 2));
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[s] <= PAGE_W'(boot_page(s));
      end else if (slot_wr && (slot_idx == SLOT_W'(s))) begin
        tbl[s] <= slot_data;
      end else if (IS_TOP && remap_stb) begin
        tbl[s] <= {remap_bank, HALF};
      end
    end
  end
endmodule

// File: rtl/pmm_xlate.sv
module pmm_xlate
  import pmm_pkg::*;
#(
  parameter int SLOT_N    = 8,
  parameter int PAGE_W    = 8,
  parameter int RAM_PAGES = 224,
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int OFF_W  = 16 - SLOT_W,
  localparam int PHYS_W = PAGE_W + OFF_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [15:0]                   cpu_addr,
  input  logic [SLOT_N-1:0][PAGE_W-1:0] tbl,
  input  legacy_t                       st,
  input  logic                          altrom_en,
  output logic [PHYS_W-1:0]             phys_addr,
  output logic                          rom_sel,
  output logic                          alt_sel,
  output logic                          unmapped
);
  logic [SLOT_W-1:0] slot;
  logic [PAGE_W-1:0] page;
  logic              hit_rom;
  logic [15:0]       rom_addr;

  always_comb begin
    slot     = cpu_addr[15 -: SLOT_W];
    page     = tbl[slot];
    hit_rom  = (cpu_addr[15:14] == 2'b00) && (page == PAGE_W'(ROM_CODE));
    rom_addr = altrom_en ? {1'b0, st.rom_lo, cpu_addr[13:0]}
                         : {st.rom_hi, st.rom_lo, cpu_addr[13:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      rom_sel   <= 1'b0;
      alt_sel   <= 1'b0;
      unmapped  <= 1'b0;
    end else if (hit_rom) begin
      phys_addr <= PHYS_W'(rom_addr);
      rom_sel   <= 1'b1;
      alt_sel   <= altrom_en;
      unmapped  <= 1'b0;
    end else begin
      phys_addr <= {page, cpu_addr[OFF_W-1:0]};
      rom_sel   <= 1'b0;
      alt_sel   <= 1'b0;
      unmapped  <= (int'(page) >= RAM_PAGES);
    end
  end
endmodule

// File: rtl/mem_page_mapper.sv
module mem_page_mapper
  import pmm_pkg::*;
#(
  parameter int SLOT_N    = 8,
  parameter int PAGE_W    = 8,
  parameter int RAM_PAGES = 224,
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int PHYS_W = PAGE_W + 16 - SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic              io_wr,
  input  logic [15:0]       io_port,
  input  logic [7:0]        io_data,
  input  logic              slot_wr,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [PAGE_W-1:0] slot_data,
  input  logic              altrom_en,
  input  logic [7:0]        mem_rdata,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              rom_sel,
  output logic              alt_sel,
  output logic              unmapped,
  output logic [7:0]        cpu_rdata
);
  legacy_t                       legacy_st;
  logic                          remap_stb;
  logic [PAGE_W-2:0]             remap_bank;
  logic [SLOT_N-1:0][PAGE_W-1:0] slot_tbl;

  pmm_legacy_ports #(.BANK_W(PAGE_W - 1)) u_ports (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
    .st(legacy_st), .remap_stb(remap_stb), .remap_bank(remap_bank)
  );

  pmm_slot_table #(.SLOT_N(SLOT_N), .PAGE_W(PAGE_W)) u_table (
    .clk(clk), .rst(rst), .slot_wr(slot_wr), .slot_idx(slot_idx),
    .slot_data(slot_data), .remap_stb(remap_stb), .remap_bank(remap_bank),
    .tbl(slot_tbl)
  );

  pmm_xlate #(.SLOT_N(SLOT_N), .PAGE_W(PAGE_W), .RAM_PAGES(RAM_PAGES)) u_xlate (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .tbl(slot_tbl), .st(legacy_st),
    .altrom_en(altrom_en), .phys_addr(phys_addr), .rom_sel(rom_sel),
    .alt_sel(alt_sel), .unmapped(unmapped)
  );

  assign cpu_rdata = unmapped ? 8'hFF : mem_rdata;
endmodule

// File: rtl/pmm_checker.sv
module pmm_checker #(
  parameter int SLOT_N = 8,
  parameter int PAGE_W = 8,
  parameter int PHYS_W = 21
) (
  input logic                          clk,
  input logic                          rst,
  input logic [15:0]                   cpu_addr,
  input logic                          io_wr,
  input logic [15:0]                   io_port,
  input logic                          slot_wr,
  input logic                          lock,
  input logic [SLOT_N-1:0][PAGE_W-1:0] tbl,
  input logic [PHYS_W-1:0]             phys_addr,
  input logic                          rom_sel,
  input logic                          alt_sel,
  input logic                          unmapped
);
  AST_ROM_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    rom_sel |-> ($past(cpu_addr[15:14]) == 2'b00)); // R3
  AST_ROM_NOT_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    rom_sel |-> !unmapped); // R8
  AST_ALT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    alt_sel |-> (rom_sel && (phys_addr[PHYS_W-1:15] == '0))); // R9
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock); // R7
  AST_LOCKED_TABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lock && !slot_wr) |=> $stable(tbl)); // R7
  AST_REMAP_PAIR: assert property (@(posedge clk) disable iff (rst)
    (io_wr && (io_port == 16'h7FFD) && !lock && !slot_wr)
    |=> ((tbl[SLOT_N-2][0] == 1'b0) &&
         (tbl[SLOT_N-1] == PAGE_W'(tbl[SLOT_N-2] + 1'b1)))); // R5
endmodule

bind mem_page_mapper pmm_checker #(
  .SLOT_N(SLOT_N), .PAGE_W(PAGE_W), .PHYS_W(PHYS_W)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .io_wr(io_wr), .io_port(io_port),
  .slot_wr(slot_wr), .lock(legacy_st.lock), .tbl(slot_tbl),
  .phys_addr(phys_addr), .rom_sel(rom_sel), .alt_sel(alt_sel),
  .unmapped(unmapped)
);

// File: tb/mem_page_mapper_tb.sv
module mem_page_mapper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        io_wr = 1'b0;
  logic [15:0] io_port = '0;
  logic [7:0]  io_data = '0;
  logic        slot_wr = 1'b0;
  logic [2:0]  slot_idx = '0;
  logic [7:0]  slot_data = '0;
  logic        altrom_en = 1'b0;
  logic [7:0]  mem_rdata = 8'h5A;
  logic [20:0] phys_addr;
  logic        rom_sel, alt_sel, unmapped;
  logic [7:0]  cpu_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mem_page_mapper #(.RAM_PAGES(96)) u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .io_wr(io_wr), .io_port(io_port),
    .io_data(io_data), .slot_wr(slot_wr), .slot_idx(slot_idx),
    .slot_data(slot_data), .altrom_en(altrom_en), .mem_rdata(mem_rdata),
    .phys_addr(phys_addr), .rom_sel(rom_sel), .alt_sel(alt_sel),
    .unmapped(unmapped), .cpu_rdata(cpu_rdata)
  );

  // {slot, page, cpu_addr, expected phys_addr, expected unmapped}
  localparam logic [48:0] VECS [0:7] = '{
    {3'd2, 8'h05, 16'h4123, 21'h00A123, 1'b0},
    {3'd3, 8'h5F, 16'h7FFF, 21'h0BFFFF, 1'b0},
    {3'd4, 8'h60, 16'h8000, 21'h0C0000, 1'b1},
    {3'd5, 8'hFF, 16'hA001, 21'h1FE001, 1'b1},
    {3'd7, 8'h00, 16'hFFFF, 21'h001FFF, 1'b0},
    {3'd6, 8'h2A, 16'hC800, 21'h054800, 1'b0},
    {3'd1, 8'h11, 16'h2345, 21'h022345, 1'b0},
    {3'd0, 8'h40, 16'h1ABC, 21'h081ABC, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] p, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_port = p; io_data = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic slot_write(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); slot_wr = 1'b1; slot_idx = s; slot_data = d;
    @(negedge clk); slot_wr = 1'b0;
  endtask

  task automatic lookup(input logic [15:0] a);
    @(negedge clk); cpu_addr = a;
    @(negedge clk);
  endtask

  task automatic chk_ram(input string req, input logic [15:0] a, input logic [20:0] pa, input logic unm);
    lookup(a);
    chk(req, {11'b0, phys_addr}, {11'b0, pa});
    chk(req, {31'b0, unmapped}, {31'b0, unm});
    chk(req, {31'b0, rom_sel}, 32'd0);
  endtask

  task automatic chk_rom(input string req, input logic [15:0] a, input logic [20:0] pa, input logic alt);
    lookup(a);
    chk(req, {11'b0, phys_addr}, {11'b0, pa});
    chk(req, {31'b0, rom_sel}, 32'd1);
    chk(req, {31'b0, alt_sel}, {31'b0, alt});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: boot map
    chk_rom("R1 rom0 base", 16'h0000, 21'h000000, 1'b0);
    chk_rom("R1 rom0 top", 16'h3FFF, 21'h003FFF, 1'b0);
    chk_ram("R1 window2", 16'h4000, 21'h014000, 1'b0);
    chk_ram("R1 window5", 16'hBFFF, 21'h00BFFF, 1'b0);
    chk_ram("R1 window7", 16'hE000, 21'h002000, 1'b0);

    // R2 R4 R8: slot-table vectors
    for (int i = 0; i < 8; i++) begin
      slot_write(VECS[i][48:46], VECS[i][45:38]);
      chk_ram("R2 R4 R8 vector", VECS[i][37:22], VECS[i][21:1], VECS[i][0]);
    end

    // R12: reset restores boot map
    do_reset();
    chk_ram("R12 window2", 16'h4000, 21'h014000, 1'b0);
    chk_rom("R12 rom", 16'h0010, 21'h000010, 1'b0);

    // R3: ROM number from both ports
    io_write(16'h7FFD, 8'h10);
    io_write(16'h1FFD, 8'h04);
    chk_rom("R3 rom3", 16'h1234, 21'h00D234, 1'b0);

    // R9: alternate ROM
    altrom_en = 1'b1;
    chk_rom("R9 alt", 16'h1234, 21'h005234, 1'b1);
    altrom_en = 1'b0;

    // R4 R8: 0xFF above window 1 is RAM, forced read data
    slot_write(3'd2, 8'hFF);
    chk_ram("R4 ff ram", 16'h4000, 21'h1FE000, 1'b1);
    chk("R8 rdata ff", {24'b0, cpu_rdata}, 32'hFF);
    slot_write(3'd2, 8'h03);
    chk_ram("R8 mapped", 16'h4001, 21'h006001, 1'b0);
    chk("R8 rdata pass", {24'b0, cpu_rdata}, 32'h5A);

    // R5: bank port rewrites windows 6/7
    io_write(16'h7FFD, 8'h13);
    chk_ram("R5 win6", 16'hC010, 21'h00C010, 1'b0);
    chk_ram("R5 win7", 16'hE010, 21'h00E010, 1'b0);

    // R6: extension port bits
    io_write(16'hDFFD, 8'h02);
    chk_ram("R6 win6", 16'hC000, 21'h04C000, 1'b0);
    chk_ram("R6 win7", 16'hE001, 21'h04E001, 1'b0);
    io_write(16'hDFFD, 8'h06);
    chk_ram("R6 R8 beyond", 16'hC000, 21'h0CC000, 1'b1);

    // R11: near-miss port ignored
    io_write(16'h7FFC, 8'h05);
    chk_ram("R11 no decode", 16'hC000, 21'h0CC000, 1'b1);

    // R10: same-cycle slot write wins
    @(negedge clk);
    io_wr = 1'b1; io_port = 16'h7FFD; io_data = 8'h11;
    slot_wr = 1'b1; slot_idx = 3'd6; slot_data = 8'h07;
    @(negedge clk); io_wr = 1'b0; slot_wr = 1'b0;
    chk_ram("R10 win6 slot", 16'hC000, 21'h00E000, 1'b0);
    chk_ram("R10 win7 port", 16'hE000, 21'h0C6000, 1'b1);

    // R7: lock
    io_write(16'h7FFD, 8'h30);
    chk_ram("R7 lock write applied", 16'hC000, 21'h0C0000, 1'b1);
    io_write(16'hDFFD, 8'h00);
    io_write(16'h7FFD, 8'h00);
    io_write(16'h1FFD, 8'h00);
    chk_ram("R7 bank frozen", 16'hC000, 21'h0C0000, 1'b1);
    chk_rom("R7 rom frozen", 16'h0000, 21'h00C000, 1'b0);
    slot_write(3'd6, 8'h05);
    chk_ram("R7 slot still works", 16'hC000, 21'h00A000, 1'b0);

    // R12: reset clears the lock
    do_reset();
    io_write(16'h7FFD, 8'h02);
    chk_ram("R12 unlocked", 16'hC000, 21'h008000, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule